// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one DMA channel that follows a chain of descriptors kept in memory. For each descriptor it moves a given number of data elements from a source address to a destination address. Software loads the first descriptor into the channel's registers (source, destination, link, control and count) while the channel is idle. It then writes the configuration register with the enable bit set. The engine issues one data beat per element on a beat port and moves the addresses forward as the control word asks. When the count reaches zero it either stops or reads the next descriptor, one word at a time, through a simple word-read memory port.

Each descriptor in memory takes an 8-word (32-byte) slot. Only the first five words are read: source, destination, link, control, count. The count is a 25-bit field in its own word. The transfer length always comes from that count; a peripheral that tries to end the transfer is refused when the configuration is written. While the channel runs, a remaining-byte value is available on a port. The channel signals a single-cycle terminal-count pulse when the chain ends normally and holds an error flag when it refuses a start or meets a bad descriptor.

Top module: `lldma_channel`

## Requirements
- R1: Each descriptor fetch reads the five words at byte addresses B, B+4, B+8, B+12 and B+16 in that order, where B is the link value with bit 0 cleared. The words are taken as source, destination, link, control and count. While these reads are in progress, `mem_master` equals bit 0 of the link that pointed to the descriptor.
- R2: A descriptor issues exactly count beats, where count is bits [24:0] of the count word; bits [31:25] are ignored. A count of zero issues no beat. Each beat reports its element width code on `beat_size`, taken from control bits [1:0] (0 = 8-bit, 1 = 16-bit, 2 = 32-bit).
- R3: After each accepted beat, the source address moves forward by the element size in bytes (1, 2 or 4) if control bit 4 is set, and otherwise stays the same. The destination address follows the same rule with control bit 5.
- R4: When a descriptor's count runs out and bits [31:1] of its link are zero, `active` clears and `tc_pulse` is high for exactly one cycle. The chain ends without any further fetch.
- R5: Register writes use the following addresses: 0 source, 1 destination, 2 link, 3 control, 4 count, 5 configuration. A configuration write while idle with bit 0 = 1 starts the channel. With bit 0 = 0 it does not. All register writes while `active` is high are ignored.
- R6: A configuration write with bit 0 and bit 1 both set (peripheral-ended flow) sets `err_flag` and does not start the channel.
- R7: A width code of 3 in control bits [1:0] or [3:2] sets `err_flag`. This applies both at start and in a fetched descriptor. The channel stops with no beat from that descriptor and no terminal pulse. The error flag is cleared by the next configuration write made while idle.
- R8: `remaining_bytes` equals the current count times the element size. It drops by one element size for each accepted beat.
- R9: During and after reset the channel is idle: `active`, `tc_pulse`, `err_flag`, `mem_req` and `beat_valid` are low and `remaining_bytes` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0..5) |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_master | output | 1 | Bus master selected for this fetch |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| beat_valid | output | 1 | A data beat is offered |
| beat_ready | input | 1 | Beat accepted in this cycle |
| beat_src | output | 32 | Source byte address of the beat |
| beat_dst | output | 32 | Destination byte address of the beat |
| beat_size | output | 2 | Element width code of the beat |
| remaining_bytes | output | 27 | Bytes still to move in the current descriptor |
| active | output | 1 | Channel enabled; clears itself at the end |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| err_flag | output | 1 | Refused start or bad descriptor |

## Verification
On every cycle the assertions check the following:
- `tc_pulse` is a single-cycle event seen only while idle.
- No fetch or beat is issued while idle, and a fetch and a beat are never offered together.
- A stalled beat keeps its addresses.
- `remaining_bytes` drops by exactly one element per accepted beat.
- A peripheral-flow configuration always results in an error with no start.

Only the bench scenarios can show the order and addresses of the descriptor reads, and the exact beat sequence across a whole chain with mixed widths and increment settings. The same holds for the stop on a bad fetched descriptor and for the fact that writes made during a run have no effect.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_FETCH = 2'd2
  } chan_state_e;

  // register select codes; fetch word index uses the same codes 0..4
  localparam int SEL_SRC   = 0;
  localparam int SEL_DST   = 1;
  localparam int SEL_LINK  = 2;
  localparam int SEL_CTRL  = 3;
  localparam int SEL_COUNT = 4;
  localparam int SEL_CFG   = 5;

  // control word fields
  localparam int CTL_SW   = 0;  // [1:0] source element width
  localparam int CTL_DW   = 2;  // [3:2] destination element width
  localparam int CTL_SINC = 4;
  localparam int CTL_DINC = 5;
  localparam int CTL_W    = 6;

  // configuration word fields
  localparam int CFG_EN   = 0;
  localparam int CFG_FLOW = 1;

  localparam logic [1:0] WIDTH_BAD = 2'd3;
endpackage

// File: rtl/lldma_datapath.sv
module lldma_datapath
  import lldma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 25,
  parameter int IW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [AW-1:0]    wr_data,
  input  logic             beat_done,
  output logic [AW-1:0]    src_q,
  output logic [AW-1:0]    dst_q,
  output logic [AW-1:0]    link_q,
  output logic [CTL_W-1:0] ctrl_q,
  output logic [CW-1:0]    cnt_q
);
  localparam int NPTR = 2;

  logic [AW-1:0]    step;
  logic [CW-1:0]    cnt_d;
  logic [AW-1:0]    link_d;
  logic [CTL_W-1:0] ctrl_d;

  assign step = {{(AW-1){1'b0}}, 1'b1} << ctrl_q[CTL_SW +: 2];

  // source (g=0) and destination (g=1) pointers share one structure
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [AW-1:0] ptr_q, ptr_d;
    logic          inc;
    assign inc = ctrl_q[CTL_SINC + g];
    always_comb begin
      ptr_d = ptr_q;
      if (wr_en && (wr_idx == IW'(SEL_SRC + g))) ptr_d = wr_data;
      else if (beat_done && inc)                 ptr_d = ptr_q + step;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
    end
  end

  assign src_q = g_ptr[0].ptr_q;
  assign dst_q = g_ptr[1].ptr_q;

  always_comb begin
    link_d = link_q;
    ctrl_d = ctrl_q;
    cnt_d  = cnt_q;
    if (wr_en && wr_idx == IW'(SEL_LINK)) link_d = wr_data;
    if (wr_en && wr_idx == IW'(SEL_CTRL)) ctrl_d = wr_data[CTL_W-1:0];
    if (wr_en && wr_idx == IW'(SEL_COUNT)) cnt_d = wr_data[CW-1:0];
    else if (beat_done)                    cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else begin
      link_q <= link_d;
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/lldma_remain.sv
module lldma_remain #(
  parameter  int CW = 25,
  localparam int RW = CW + 2
) (
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    width,
  output logic [RW-1:0] bytes
);
  always_comb begin
    case (width)
      2'd0:    bytes = RW'(cnt);
      2'd1:    bytes = RW'(cnt) << 1;
      2'd2:    bytes = RW'(cnt) << 2;
      default: bytes = '0;
    endcase
  end
endmodule

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IW   = 3,
  parameter int USED = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_en,
  input  logic          cfg_flow,
  input  logic [1:0]    src_w,
  input  logic [1:0]    dst_w,
  input  logic          cnt_zero,
  input  logic [AW-1:0] link_q,
  input  logic          mem_ack,
  output logic          active,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_master,
  output logic          beat_valid,
  output logic          fetch_we,
  output logic [IW-1:0] fetch_idx,
  output logic          tc_pulse,
  output logic          err_flag
);
  chan_state_e   state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] base_q, base_d;
  logic          mst_q, mst_d;
  logic          tc_q, tc_d;
  logic          err_q, err_d;

  logic width_bad, link_null, last_word;
  assign width_bad = (src_w == WIDTH_BAD) || (dst_w == WIDTH_BAD);
  assign link_null = (link_q[AW-1:1] == '0);
  assign last_word = (idx_q == IW'(USED - 1));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    base_d  = base_q;
    mst_d   = mst_q;
    tc_d    = 1'b0;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (cfg_wr) begin
          err_d = 1'b0;
          if (cfg_en) begin
            if (cfg_flow || width_bad) err_d   = 1'b1;
            else                       state_d = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (cnt_zero) begin
          if (link_null) begin
            state_d = ST_IDLE;
            tc_d    = 1'b1;
          end else begin
            state_d = ST_FETCH;
            idx_d   = '0;
            base_d  = {link_q[AW-1:1], 1'b0};
            mst_d   = link_q[0];
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          idx_d = idx_q + IW'(1);
          if (last_word) begin
            if (width_bad) begin
              state_d = ST_IDLE;
              err_d   = 1'b1;
            end else begin
              state_d = ST_XFER;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      mst_q   <= 1'b0;
      tc_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      mst_q   <= mst_d;
      tc_q    <= tc_d;
      err_q   <= err_d;
    end
  end

  assign active     = (state_q != ST_IDLE);
  assign mem_req    = (state_q == ST_FETCH);
  assign mem_addr   = base_q + (AW'(idx_q) << 2);
  assign mem_master = mst_q;
  assign beat_valid = (state_q == ST_XFER) && !cnt_zero;
  assign fetch_we   = mem_req && mem_ack;
  assign fetch_idx  = idx_q;
  assign tc_pulse   = tc_q;
  assign err_flag   = err_q;
endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
#(
  parameter  int AW         = 32,
  parameter  int CW         = 25,
  parameter  int DESC_SLOTS = 8,
  parameter  int DESC_USED  = 5,
  localparam int RW         = CW + 2,
  localparam int IW         = $clog2(DESC_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [IW-1:0] reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_master,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] beat_src,
  output logic [AW-1:0] beat_dst,
  output logic [1:0]    beat_size,
  output logic [RW-1:0] remaining_bytes,
  output logic          active,
  output logic          tc_pulse,
  output logic          err_flag
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic             sw_wr, cfg_wr, fetch_we, beat_done, wr_en;
  logic [IW-1:0]    fetch_idx, wr_idx;
  logic [AW-1:0]    wr_data, src_q, dst_q, link_q;
  logic [CTL_W-1:0] ctrl_q;
  logic [CW-1:0]    cnt_q;

  assign sw_wr     = reg_wr && !active && (reg_addr < IW'(DESC_USED));
  assign cfg_wr    = reg_wr && !active && (reg_addr == IW'(SEL_CFG));
  assign beat_done = beat_valid && beat_ready;
  assign wr_en     = sw_wr || fetch_we;
  assign wr_idx    = fetch_we ? fetch_idx : reg_addr;
  assign wr_data   = fetch_we ? mem_rdata : reg_wdata;

  lldma_datapath #(.AW(AW), .CW(CW), .IW(IW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .beat_done (beat_done),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .link_q    (link_q),
    .ctrl_q    (ctrl_q),
    .cnt_q     (cnt_q)
  );

  lldma_ctrl #(.AW(AW), .IW(IW), .USED(DESC_USED)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cfg_wr     (cfg_wr),
    .cfg_en     (reg_wdata[CFG_EN]),
    .cfg_flow   (reg_wdata[CFG_FLOW]),
    .src_w      (ctrl_q[CTL_SW +: 2]),
    .dst_w      (ctrl_q[CTL_DW +: 2]),
    .cnt_zero   (cnt_q == '0),
    .link_q     (link_q),
    .mem_ack    (mem_ack),
    .active     (active),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_master (mem_master),
    .beat_valid (beat_valid),
    .fetch_we   (fetch_we),
    .fetch_idx  (fetch_idx),
    .tc_pulse   (tc_pulse),
    .err_flag   (err_flag)
  );

  lldma_remain #(.CW(CW)) u_rem (
    .cnt   (cnt_q),
    .width (ctrl_q[CTL_SW +: 2]),
    .bytes (remaining_bytes)
  );

  assign beat_src  = src_q;
  assign beat_dst  = dst_q;
  assign beat_size = ctrl_q[CTL_SW +: 2];
endmodule

// File: rtl/lldma_channel_chk.sv
module lldma_channel_chk #(
  parameter int AW = 32,
  parameter int RW = 27,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [IW-1:0] reg_addr,
  input logic [1:0]    cfg_bits,
  input logic          mem_req,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] beat_src,
  input logic [AW-1:0] beat_dst,
  input logic [1:0]    beat_size,
  input logic [RW-1:0] remaining_bytes,
  input logic          active,
  input logic          tc_pulse,
  input logic          err_flag
);
  // R4: terminal pulse lasts one cycle and is seen with the channel idle
  p_tc_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);
  p_tc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> !active);

  // R1: no fetch and no beat while idle, never both at once
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mem_req && !beat_valid));
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && beat_valid));

  // R3: a stalled beat holds its addresses
  p_beat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_src) && $stable(beat_dst)));

  // R8: one element size less after every accepted beat
  p_rem_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready) |=>
      (remaining_bytes == $past(remaining_bytes) - (RW'(1) << $past(beat_size))));

  // R6: peripheral-ended flow is refused
  p_flow_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !active && reg_addr == IW'(5) && cfg_bits == 2'b11) |=> (err_flag && !active));
endmodule

bind lldma_channel lldma_channel_chk #(.AW(AW), .RW(RW), .IW(IW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_core_n),
  .reg_wr          (reg_wr),
  .reg_addr        (reg_addr),
  .cfg_bits        (reg_wdata[1:0]),
  .mem_req         (mem_req),
  .beat_valid      (beat_valid),
  .beat_ready      (beat_ready),
  .beat_src        (beat_src),
  .beat_dst        (beat_dst),
  .beat_size       (beat_size),
  .remaining_bytes (remaining_bytes),
  .active          (active),
  .tc_pulse        (tc_pulse),
  .err_flag        (err_flag)
);

// File: tb/lldma_channel_test.sv
`timescale 1ns/1ps
module lldma_channel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        mem_req, mem_master, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        beat_valid, beat_ready;
  logic [31:0] beat_src, beat_dst;
  logic [1:0]  beat_size;
  logic [26:0] remaining_bytes;
  logic        active, tc_pulse, err_flag;

  always #2 clk = ~clk;

  lldma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_master(mem_master), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_src(beat_src), .beat_dst(beat_dst), .beat_size(beat_size),
    .remaining_bytes(remaining_bytes), .active(active), .tc_pulse(tc_pulse), .err_flag(err_flag)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  bit model_on = 0;

  logic [31:0] mem [0:255];
  logic [31:0] d_src [4], d_dst [4], d_link [4], d_ctrl [4], d_cnt [4];

  logic [31:0] e_src [64], e_dst [64], e_faddr [64];
  logic [1:0]  e_sz [64];
  logic [26:0] e_rem [64];
  logic        e_fmst [64];
  int nb, nf, bi, fi, tcs;
  bit exp_err, exp_tc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input int a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // expected beats and fetches, walked from the requirements
  task automatic build_expect(input logic [31:0] cfgv);
    logic [31:0] s, d, lk, c, base;
    logic [24:0] n;
    int w, bw;
    nb = 0; nf = 0; exp_err = 0; exp_tc = 0;
    if (!cfgv[0]) return;
    if (cfgv[1]) begin exp_err = 1; return; end
    s = d_src[0]; d = d_dst[0]; lk = d_link[0]; c = d_ctrl[0]; n = d_cnt[0][24:0];
    forever begin
      if (c[1:0] == 2'd3 || c[3:2] == 2'd3) begin exp_err = 1; return; end
      w = int'(c[1:0]);
      for (int j = 0; j < int'(n); j++) begin
        e_src[nb] = s; e_dst[nb] = d; e_sz[nb] = c[1:0];
        e_rem[nb] = 27'((int'(n) - j) << w);
        nb++;
        if (c[4]) s = s + (32'd1 << w);
        if (c[5]) d = d + (32'd1 << w);
      end
      if (lk[31:1] == 31'd0) begin exp_tc = 1; return; end
      base = {lk[31:1], 1'b0};
      for (int k = 0; k < 5; k++) begin
        e_faddr[nf] = base + 32'(4 * k); e_fmst[nf] = lk[0]; nf++;
      end
      bw = int'(base[9:2]);
      s = mem[bw]; d = mem[bw + 1]; lk = mem[bw + 2]; c = mem[bw + 3]; n = mem[bw + 4][24:0];
    end
  endtask

  // memory and beat sink; all decisions at the falling edge
  initial begin
    mem_ack = 1'b0; beat_ready = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack   = mem_req && ($urandom % 4 != 0);
      mem_rdata = mem[mem_addr[9:2]];
      if (mem_ack && model_on) begin
        if (fi < nf) begin
          check(mem_addr == e_faddr[fi], "R1", "fetch address", 64'(mem_addr), 64'(e_faddr[fi]));
          check(mem_master == e_fmst[fi], "R1", "fetch master", 64'(mem_master), 64'(e_fmst[fi]));
        end else check(0, "R1", "unexpected fetch", 64'(mem_addr), 64'(0));
        fi++;
      end
      beat_ready = ($urandom % 3 != 0);
      if (beat_valid && model_on) begin
        if (bi < nb) begin
          check(remaining_bytes == e_rem[bi], "R8", "remaining bytes", 64'(remaining_bytes), 64'(e_rem[bi]));
          if (beat_ready) begin
            check(beat_src == e_src[bi], "R3", "beat source", 64'(beat_src), 64'(e_src[bi]));
            check(beat_dst == e_dst[bi], "R3", "beat destination", 64'(beat_dst), 64'(e_dst[bi]));
            check(beat_size == e_sz[bi], "R2", "beat size", 64'(beat_size), 64'(e_sz[bi]));
            bi++;
          end
        end else begin
          check(0, "R2", "unexpected beat", 64'(beat_src), 64'(0));
          if (beat_ready) bi++;
        end
      end
      if (tc_pulse) tcs++;
    end
  end

  task automatic gen_chain(input int len, input int maxcnt);
    int ks;
    ks = 1 + int'($urandom % 32'(8 - (len - 1)));
    for (int i = 0; i < len; i++) begin
      d_src[i]  = $urandom;
      d_dst[i]  = $urandom;
      d_ctrl[i] = ($urandom & 32'hFFFF_FFC0) | {26'd0, 1'($urandom), 1'($urandom),
                  2'($urandom % 3), 2'($urandom % 3)};
      d_cnt[i]  = ($urandom & 32'hFE00_0000) | 32'($urandom % 32'(maxcnt + 1));
      if (i < len - 1) d_link[i] = 32'(32 * (ks + i)) | 32'($urandom % 2);
      else             d_link[i] = 32'($urandom % 2);
    end
    for (int i = 1; i < len; i++) begin
      int b;
      b = 8 * (ks + i - 1);
      mem[b] = d_src[i]; mem[b + 1] = d_dst[i]; mem[b + 2] = d_link[i];
      mem[b + 3] = d_ctrl[i]; mem[b + 4] = d_cnt[i];
      for (int p = 5; p < 8; p++) mem[b + p] = $urandom;
    end
  endtask

  task automatic run_chain(input logic [31:0] cfgv, input bit poke, input string tag);
    build_expect(cfgv);
    bi = 0; fi = 0; tcs = 0; model_on = 1;
    write_reg(0, d_src[0]); write_reg(1, d_dst[0]); write_reg(2, d_link[0]);
    write_reg(3, d_ctrl[0]); write_reg(4, d_cnt[0]);
    write_reg(5, cfgv);
    if (poke) begin
      repeat (3) @(negedge clk);
      check(active == 1'b1, "R5", "still running before pokes", 64'(active), 64'(1));
      write_reg(0, 32'hDEAD_BEEF); write_reg(4, 32'd9); write_reg(3, 32'h3F); write_reg(5, 32'd1);
    end
    while (active) @(negedge clk);
    repeat (2) @(negedge clk);
    check(bi == nb, tag, "beat count", 64'(bi), 64'(nb));
    check(fi == nf, "R1", "fetch count", 64'(fi), 64'(nf));
    check(tcs == int'(exp_tc), "R4", "terminal pulses", 64'(tcs), 64'(exp_tc));
    check(err_flag == exp_err, "R7", "error flag", 64'(err_flag), 64'(exp_err));
    check(active == 1'b0, "R4", "enable cleared", 64'(active), 64'(0));
    model_on = 0;
  endtask

  task automatic check_idle(input string what);
    check(active == 1'b0, "R9", {what, " active"}, 64'(active), 64'(0));
    check(tc_pulse == 1'b0, "R9", {what, " tc"}, 64'(tc_pulse), 64'(0));
    check(err_flag == 1'b0, "R9", {what, " err"}, 64'(err_flag), 64'(0));
    check(mem_req == 1'b0, "R9", {what, " mem_req"}, 64'(mem_req), 64'(0));
    check(beat_valid == 1'b0, "R9", {what, " beat_valid"}, 64'(beat_valid), 64'(0));
    check(remaining_bytes == '0, "R9", {what, " remaining"}, 64'(remaining_bytes), 64'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    check_idle("in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("after reset");

    // R2 R3: single descriptor, 8-bit, both addresses stepping
    d_src[0] = 32'h1000; d_dst[0] = 32'h2000; d_link[0] = 32'd0;
    d_ctrl[0] = 32'h30; d_cnt[0] = 32'hFE00_0004;
    run_chain(32'd1, 0, "R2");

    // R2: zero count, null link: no beat, one pulse
    d_cnt[0] = 32'd0;
    run_chain(32'd1, 0, "R2");

    // R5: enable bit clear does not start
    write_reg(5, 32'd0);
    check(active == 1'b0, "R5", "no start without enable", 64'(active), 64'(0));

    // R6: peripheral flow refused
    d_cnt[0] = 32'd3;
    run_chain(32'd3, 0, "R6");
    check(err_flag == 1'b1, "R6", "flow error held", 64'(err_flag), 64'(1));

    // R7: bad width at start
    d_ctrl[0] = 32'h0000_0013;
    run_chain(32'd1, 0, "R7");

    // R7: bad destination width in a fetched descriptor
    gen_chain(2, 4);
    d_cnt[0] = 32'd2;
    mem[8 * int'(d_link[0][31:5]) + 3] = 32'h0000_000C;
    run_chain(32'd1, 0, "R7");

    // R5: writes during a run are ignored
    d_src[0] = 32'h4000; d_dst[0] = 32'h8000; d_link[0] = 32'd0;
    d_ctrl[0] = 32'h31; d_cnt[0] = 32'd30;
    run_chain(32'd1, 1, "R5");

    // random chains
    for (int r = 0; r < 24; r++) begin
      gen_chain(1 + int'($urandom % 4), 5);
      run_chain(32'd1, 0, "R2");
    end

    // R8: full 25-bit count at 32-bit width, then R9: abort by reset
    model_on = 0;
    write_reg(0, 32'h0); write_reg(1, 32'h0); write_reg(2, 32'd0);
    write_reg(3, 32'h32); write_reg(4, 32'hFFFF_FFFF);
    write_reg(5, 32'd1);
    check(remaining_bytes == 27'h7FF_FFFC, "R8", "largest count bytes",
          64'(remaining_bytes), 64'h7FF_FFFC);
    check(active == 1'b1, "R5", "started", 64'(active), 64'(1));
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("reset during run");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("after abort");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule